// File: doc/BRIEF.md
# Runahead In-Order Retirement Controller

This block is a circular reorder buffer that retires instructions strictly in program order and adds a runahead mode. Dispatch allocates an entry at the tail and gets back the entry's tag. Writeback uses that tag to mark the entry done. Only the oldest entry, at the head, is considered for retirement. In normal mode a head that is not done holds back every younger entry.

The exception is a load whose cache miss is still outstanding. The cache side flags such a load by tag. When that load reaches the head, it leaves at once with its result forced to zero. The controller takes a checkpoint of architectural state and records the load's program counter. Younger entries keep draining in order, but none of them commits: stores do not reach memory, and registers are not updated for good. The independent work done in this window warms the cache. When the missing data returns, the controller restores the checkpoint, empties the buffer and redirects fetch to the saved program counter, so that the load and everything after it run again.

Top module: `runahead_rob`

## Requirements
- R1: Allocation writes the tail entry and returns its tag on `allocTag` (the tail index, wrapping modulo DEPTH). `allocReady` is low when all DEPTH entries are in use, and an allocation attempted while full is ignored.
- R2: An entry is marked done by a writeback carrying its tag. Entries retire from the head only, at most one per cycle, in allocation order, whatever the order of their writebacks. Retirement occurs in the cycle after the writeback edge.
- R3: A head entry that is not done, and is not a load with a flagged miss, blocks all younger entries from retiring.
- R4: In normal mode a retiring done entry has `retireCommit`=1 and `retireBogus`=0.
- R5: In normal mode a head load that is flagged as missing and is not done retires with `retireBogus`=1 (its value is taken as zero) and `retireCommit`=0. In the same cycle `ckptSave` pulses and the load's PC is saved. `runahead` is 1 from the next cycle.
- R6: While `runahead` is 1, every retirement has `retireCommit`=0.
- R7: A further missing load that reaches the head during runahead also retires with `retireBogus`=1, but `ckptSave` does not pulse and the saved PC is kept.
- R8: `missReturn` during runahead drives, in the same cycle, `ckptRestore`=1, `redirectValid`=1 and `redirectPc` = the saved PC. From the next cycle the buffer is empty and `runahead` is 0.
- R9: `missReturn` in normal mode is ignored: no redirect, no restore, and the buffer contents are kept.
- R10: `flush` empties the buffer in one cycle (`robEmpty`=1, `allocReady`=1 afterwards) and leaves the mode unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Empty all entries this cycle |
| allocValid | input | 1 | Dispatch allocation request |
| allocPc | input | PC_W | PC of the allocated instruction |
| allocIsLoad | input | 1 | Allocated instruction is a load |
| allocReady | output | 1 | Buffer not full |
| allocTag | output | $clog2(DEPTH) | Tag of the entry being allocated |
| wbValid | input | 1 | Writeback done strobe |
| wbTag | input | $clog2(DEPTH) | Tag of the entry written back |
| missValid | input | 1 | Flag a load as missing in the cache |
| missTag | input | $clog2(DEPTH) | Tag of the missing load |
| missReturn | input | 1 | Data for the runahead-triggering load has arrived |
| retireValid | output | 1 | Head entry retires this cycle |
| retirePc | output | PC_W | PC of the retiring entry |
| retireBogus | output | 1 | Retiring load uses a zero value |
| retireCommit | output | 1 | Retirement updates architectural state and memory |
| ckptSave | output | 1 | Take a checkpoint of architectural state |
| ckptRestore | output | 1 | Restore the checkpoint |
| redirectValid | output | 1 | Refetch request |
| redirectPc | output | PC_W | Refetch target |
| runahead | output | 1 | Runahead mode active |
| robEmpty | output | 1 | No entries in use |

## Verification
The bench builds the block with DEPTH=4 and PC_W=16. With four entries, a handful of allocations fills the buffer, and the pointers wrap several times within short directed scenarios. This exercises the full condition, the ignored extra allocation and the tag wrap next to the runahead entry, the nested miss, the restore and the flush cases. The narrow PC keeps the saved and redirected values easy to compare.

// File: rtl/rar_pkg.sv
package rar_pkg;

  typedef enum logic {
    MODE_NORMAL   = 1'b0,
    MODE_RUNAHEAD = 1'b1
  } rarMode_e;

  typedef struct packed {
    logic pop;       // remove the head entry
    logic clearAll;  // drop every entry, reset pointers
    logic save;      // capture the head PC as the replay point
  } rarStrobe_t;

endpackage

// File: rtl/rar_dpath.sv
module rar_dpath
  import rar_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PC_W  = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  rarStrobe_t               stb,
  input  logic                     allocValid,
  input  logic [PC_W-1:0]          allocPc,
  input  logic                     allocIsLoad,
  input  logic                     wbValid,
  input  logic [$clog2(DEPTH)-1:0] wbTag,
  input  logic                     missValid,
  input  logic [$clog2(DEPTH)-1:0] missTag,
  output logic                     allocReady,
  output logic [$clog2(DEPTH)-1:0] allocTag,
  output logic                     headValid,
  output logic                     headReady,
  output logic                     headIsLoad,
  output logic                     headMiss,
  output logic [PC_W-1:0]          headPc,
  output logic [PC_W-1:0]          savedPc,
  output logic                     isEmpty
);

  localparam int IDX_W = $clog2(DEPTH);
  localparam int PTR_W = IDX_W + 1;

  logic [PTR_W-1:0] headPtr, tailPtr;
  logic [IDX_W-1:0] headIdx, tailIdx;
  logic             isFull;
  logic             doAlloc;

  logic             entValid [DEPTH];
  logic             entReady [DEPTH];
  logic             entLoad  [DEPTH];
  logic             entMiss  [DEPTH];
  logic [PC_W-1:0]  entPc    [DEPTH];

  assign headIdx    = headPtr[IDX_W-1:0];
  assign tailIdx    = tailPtr[IDX_W-1:0];
  assign isEmpty    = (headPtr == tailPtr);
  assign isFull     = (headIdx == tailIdx) && (headPtr[IDX_W] != tailPtr[IDX_W]);
  assign allocReady = !isFull;
  assign allocTag   = tailIdx;
  assign doAlloc    = allocValid && !isFull && !stb.clearAll;

  assign headValid  = entValid[headIdx];
  assign headReady  = entReady[headIdx];
  assign headIsLoad = entLoad[headIdx];
  assign headMiss   = entMiss[headIdx];
  assign headPc     = entPc[headIdx];

  // Pointer pair with a wrap bit distinguishing full from empty.
  always_ff @(posedge clk) begin
    if (!rstN || stb.clearAll) begin
      headPtr <= '0;
      tailPtr <= '0;
    end else begin
      if (doAlloc) tailPtr <= tailPtr + PTR_W'(1);
      if (stb.pop) headPtr <= headPtr + PTR_W'(1);
    end
  end

  // Per-entry state.
  for (genvar g = 0; g < DEPTH; g++) begin : gEntry
    logic isTail, isHead, wbHit, missHit;
    assign isTail  = doAlloc && (tailIdx == IDX_W'(g));
    assign isHead  = stb.pop && (headIdx == IDX_W'(g));
    assign wbHit   = wbValid && (wbTag == IDX_W'(g)) && entValid[g];
    assign missHit = missValid && (missTag == IDX_W'(g)) && entValid[g];

    always_ff @(posedge clk) begin
      if (!rstN || stb.clearAll) begin
        entValid[g] <= 1'b0;
        entReady[g] <= 1'b0;
        entLoad[g]  <= 1'b0;
        entMiss[g]  <= 1'b0;
        entPc[g]    <= '0;
      end else if (isTail) begin
        entValid[g] <= 1'b1;
        entReady[g] <= 1'b0;
        entLoad[g]  <= allocIsLoad;
        entMiss[g]  <= 1'b0;
        entPc[g]    <= allocPc;
      end else if (isHead) begin
        entValid[g] <= 1'b0;
      end else begin
        if (wbHit)   entReady[g] <= 1'b1;
        if (missHit) entMiss[g]  <= 1'b1;
      end
    end
  end

  // Replay point.
  always_ff @(posedge clk) begin
    if (!rstN)         savedPc <= '0;
    else if (stb.save) savedPc <= headPc;
  end

  AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (isFull && !stb.pop && !stb.clearAll) |=> isFull); // R1
  AST_NO_POP_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    stb.pop |-> !isEmpty); // R2
  AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    stb.clearAll |=> (isEmpty && allocReady)); // R10

endmodule

// File: rtl/rar_ctrl.sv
module rar_ctrl
  import rar_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       flush,
  input  logic       missReturn,
  input  logic       headValid,
  input  logic       headReady,
  input  logic       headIsLoad,
  input  logic       headMiss,
  input  logic       isEmpty,
  output rarStrobe_t stb,
  output logic       retireValid,
  output logic       retireBogus,
  output logic       retireCommit,
  output logic       ckptSave,
  output logic       ckptRestore,
  output logic       redirectValid,
  output logic       runahead
);

  rarMode_e mode, modeNext;
  logic     restore, clearAll, canRetire, bogus;

  assign runahead  = (mode == MODE_RUNAHEAD);
  assign restore   = runahead && missReturn;
  assign clearAll  = restore || flush;
  assign canRetire = headValid && !clearAll &&
                     (headReady || (headIsLoad && headMiss));
  assign bogus     = canRetire && !headReady;

  assign retireValid   = canRetire;
  assign retireBogus   = bogus;
  assign retireCommit  = canRetire && !bogus && !runahead;
  assign ckptSave      = bogus && !runahead;
  assign ckptRestore   = restore;
  assign redirectValid = restore;

  assign stb.pop      = canRetire;
  assign stb.clearAll = clearAll;
  assign stb.save     = ckptSave;

  always_comb begin
    modeNext = mode;
    if (restore)       modeNext = MODE_NORMAL;
    else if (ckptSave) modeNext = MODE_RUNAHEAD;
  end

  always_ff @(posedge clk) begin
    if (!rstN) mode <= MODE_NORMAL;
    else       mode <= modeNext;
  end

  AST_HEAD_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (headValid && !headReady && !headMiss) |-> !retireValid); // R3
  AST_SAVE_ENTERS: assert property (@(posedge clk) disable iff (!rstN)
    ckptSave |=> runahead); // R5
  AST_RUN_NO_COMMIT: assert property (@(posedge clk) disable iff (!rstN)
    (runahead && retireValid) |-> !retireCommit); // R6
  AST_NO_NESTED: assert property (@(posedge clk) disable iff (!rstN)
    runahead |-> !ckptSave); // R7
  AST_RESTORE_EXIT: assert property (@(posedge clk) disable iff (!rstN)
    ckptRestore |=> (!runahead && isEmpty)); // R8
  AST_NORMAL_NO_REDIRECT: assert property (@(posedge clk) disable iff (!rstN)
    !runahead |-> !redirectValid); // R9

endmodule

// File: rtl/runahead_rob.sv
module runahead_rob
  import rar_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int PC_W  = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     flush,
  input  logic                     allocValid,
  input  logic [PC_W-1:0]          allocPc,
  input  logic                     allocIsLoad,
  output logic                     allocReady,
  output logic [$clog2(DEPTH)-1:0] allocTag,
  input  logic                     wbValid,
  input  logic [$clog2(DEPTH)-1:0] wbTag,
  input  logic                     missValid,
  input  logic [$clog2(DEPTH)-1:0] missTag,
  input  logic                     missReturn,
  output logic                     retireValid,
  output logic [PC_W-1:0]          retirePc,
  output logic                     retireBogus,
  output logic                     retireCommit,
  output logic                     ckptSave,
  output logic                     ckptRestore,
  output logic                     redirectValid,
  output logic [PC_W-1:0]          redirectPc,
  output logic                     runahead,
  output logic                     robEmpty
);

  rarStrobe_t      stb;
  logic            headValid, headReady, headIsLoad, headMiss;
  logic [PC_W-1:0] headPc, savedPc;

  rar_dpath #(.DEPTH(DEPTH), .PC_W(PC_W)) uDpath (
    .clk         (clk),
    .rstN        (rstN),
    .stb         (stb),
    .allocValid  (allocValid),
    .allocPc     (allocPc),
    .allocIsLoad (allocIsLoad),
    .wbValid     (wbValid),
    .wbTag       (wbTag),
    .missValid   (missValid),
    .missTag     (missTag),
    .allocReady  (allocReady),
    .allocTag    (allocTag),
    .headValid   (headValid),
    .headReady   (headReady),
    .headIsLoad  (headIsLoad),
    .headMiss    (headMiss),
    .headPc      (headPc),
    .savedPc     (savedPc),
    .isEmpty     (robEmpty)
  );

  rar_ctrl uCtrl (
    .clk           (clk),
    .rstN          (rstN),
    .flush         (flush),
    .missReturn    (missReturn),
    .headValid     (headValid),
    .headReady     (headReady),
    .headIsLoad    (headIsLoad),
    .headMiss      (headMiss),
    .isEmpty       (robEmpty),
    .stb           (stb),
    .retireValid   (retireValid),
    .retireBogus   (retireBogus),
    .retireCommit  (retireCommit),
    .ckptSave      (ckptSave),
    .ckptRestore   (ckptRestore),
    .redirectValid (redirectValid),
    .runahead      (runahead)
  );

  assign retirePc   = headPc;
  assign redirectPc = savedPc;

endmodule

// File: tb/sim_runahead_rob.sv
module sim_runahead_rob;

  localparam int DEPTH = 4;
  localparam int PC_W  = 16;
  localparam int IDX_W = $clog2(DEPTH);

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             flush = 1'b0;
  logic             allocValid = 1'b0;
  logic [PC_W-1:0]  allocPc = '0;
  logic             allocIsLoad = 1'b0;
  logic             allocReady;
  logic [IDX_W-1:0] allocTag;
  logic             wbValid = 1'b0;
  logic [IDX_W-1:0] wbTag = '0;
  logic             missValid = 1'b0;
  logic [IDX_W-1:0] missTag = '0;
  logic             missReturn = 1'b0;
  logic             retireValid, retireBogus, retireCommit;
  logic [PC_W-1:0]  retirePc, redirectPc;
  logic             ckptSave, ckptRestore, redirectValid, runahead, robEmpty;

  runahead_rob #(.DEPTH(DEPTH), .PC_W(PC_W)) u0 (.*);

  always #2 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Retirement log gathered at the clock edge.
  int              logN = 0;
  logic [PC_W-1:0] logPc     [32];
  logic            logBogus  [32];
  logic            logCommit [32];
  int              saveN = 0;

  always @(posedge clk) begin
    if (rstN && retireValid && logN < 32) begin
      logPc[logN]     <= retirePc;
      logBogus[logN]  <= retireBogus;
      logCommit[logN] <= retireCommit;
      logN            <= logN + 1;
    end
    if (rstN && ckptSave) saveN <= saveN + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clearLog();
    logN  = 0;
    saveN = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic alloc(input logic [PC_W-1:0] pc, input logic ld, output logic [IDX_W-1:0] tag);
    allocValid = 1'b1; allocPc = pc; allocIsLoad = ld;
    #1 tag = allocTag;
    @(negedge clk);
    allocValid = 1'b0;
  endtask

  task automatic wb(input logic [IDX_W-1:0] tag);
    wbValid = 1'b1; wbTag = tag;
    @(negedge clk);
    wbValid = 1'b0;
  endtask

  task automatic miss(input logic [IDX_W-1:0] tag);
    missValid = 1'b1; missTag = tag;
    @(negedge clk);
    missValid = 1'b0;
  endtask

  task automatic testReset();
    check(robEmpty == 1'b1, "R1 reset empty", int'(robEmpty), 1);
    check(allocReady == 1'b1, "R1 reset allocReady", int'(allocReady), 1);
    check(retireValid == 1'b0, "R2 reset no retire", int'(retireValid), 0);
    check(runahead == 1'b0, "R5 reset normal mode", int'(runahead), 0);
  endtask

  task automatic testInOrder();
    logic [IDX_W-1:0] ta, tb, tc;
    clearLog();
    alloc(16'd10, 1'b0, ta);
    alloc(16'd11, 1'b0, tb);
    alloc(16'd12, 1'b0, tc);
    wb(tc);
    idle(2);
    check(logN == 0, "R3 head blocks younger", logN, 0);
    wb(ta);
    wb(tb);
    idle(4);
    check(logN == 3, "R2 retire count", logN, 3);
    check(logPc[0] == 16'd10 && logPc[1] == 16'd11 && logPc[2] == 16'd12,
          "R2 program order", int'(logPc[0]), 10);
    check(logCommit[0] && logCommit[1] && logCommit[2] && !logBogus[0] && !logBogus[2],
          "R4 normal commit", int'(logCommit[1]), 1);
    check(robEmpty == 1'b1, "R2 drained", int'(robEmpty), 1);
  endtask

  task automatic testFull();
    logic [IDX_W-1:0] t [DEPTH];
    logic [IDX_W-1:0] dummy;
    clearLog();
    for (int i = 0; i < DEPTH; i++) alloc(PC_W'(40 + i), 1'b0, t[i]);
    check(allocReady == 1'b0, "R1 full lowers allocReady", int'(allocReady), 0);
    check(t[1] == t[0] + IDX_W'(1), "R1 tag follows tail", int'(t[1]), int'(t[0] + IDX_W'(1)));
    alloc(16'd99, 1'b0, dummy);
    for (int i = 0; i < DEPTH; i++) wb(t[i]);
    idle(6);
    check(logN == DEPTH, "R1 ignored alloc when full", logN, DEPTH);
    check(logPc[DEPTH-1] == PC_W'(40 + DEPTH - 1), "R1 last retired pc",
          int'(logPc[DEPTH-1]), 40 + DEPTH - 1);
    check(robEmpty == 1'b1, "R1 empty after drain", int'(robEmpty), 1);
  endtask

  task automatic testRunahead();
    logic [IDX_W-1:0] tl, t1, t2, t3, t4, t5;
    clearLog();
    alloc(16'd20, 1'b1, tl);
    alloc(16'd21, 1'b0, t1);
    alloc(16'd22, 1'b0, t2);
    idle(2);
    check(logN == 0, "R3 unmarked load blocks", logN, 0);
    miss(tl);
    wb(t1);
    wb(t2);
    idle(3);
    check(runahead == 1'b1, "R5 entered runahead", int'(runahead), 1);
    check(logN == 3, "R5 retire count", logN, 3);
    check(logPc[0] == 16'd20 && logBogus[0] && !logCommit[0], "R5 bogus load retire",
          int'(logBogus[0]), 1);
    check(!logCommit[1] && !logCommit[2] && !logBogus[1], "R6 no commit in runahead",
          int'(logCommit[1]), 0);
    alloc(16'd23, 1'b1, t3);
    alloc(16'd24, 1'b0, t4);
    miss(t3);
    wb(t4);
    idle(3);
    check(logN == 5 && logPc[3] == 16'd23 && logBogus[3], "R7 second miss retires bogus",
          int'(logPc[3]), 23);
    check(saveN == 1, "R7 no nested checkpoint", saveN, 1);
    check(!logCommit[4], "R6 later retire no commit", int'(logCommit[4]), 0);
    alloc(16'd25, 1'b0, t5);
    missReturn = 1'b1;
    #1;
    check(redirectValid == 1'b1 && ckptRestore == 1'b1, "R8 restore strobes",
          int'(redirectValid), 1);
    check(redirectPc == 16'd20, "R8 redirect pc", int'(redirectPc), 20);
    @(negedge clk);
    missReturn = 1'b0;
    check(runahead == 1'b0, "R8 back to normal", int'(runahead), 0);
    check(robEmpty == 1'b1, "R8 buffer emptied", int'(robEmpty), 1);
  endtask

  task automatic testNormalReturn();
    logic [IDX_W-1:0] ta;
    alloc(16'd30, 1'b0, ta);
    missReturn = 1'b1;
    #1;
    check(redirectValid == 1'b0 && ckptRestore == 1'b0, "R9 no redirect in normal",
          int'(redirectValid), 0);
    @(negedge clk);
    missReturn = 1'b0;
    check(robEmpty == 1'b0, "R9 entries kept", int'(robEmpty), 0);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    check(robEmpty == 1'b1 && allocReady == 1'b1, "R10 flush empties", int'(robEmpty), 1);
    check(runahead == 1'b0, "R10 mode kept normal", int'(runahead), 0);
  endtask

  task automatic testFlushRunahead();
    logic [IDX_W-1:0] tl, tx;
    alloc(16'd50, 1'b1, tl);
    miss(tl);
    idle(2);
    check(runahead == 1'b1, "R5 runahead again", int'(runahead), 1);
    alloc(16'd51, 1'b0, tx);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    check(robEmpty == 1'b1, "R10 flush in runahead", int'(robEmpty), 1);
    check(runahead == 1'b1, "R10 mode kept runahead", int'(runahead), 1);
    missReturn = 1'b1;
    #1;
    check(redirectPc == 16'd50, "R8 saved pc of second episode", int'(redirectPc), 50);
    @(negedge clk);
    missReturn = 1'b0;
    check(runahead == 1'b0, "R8 exit after flush", int'(runahead), 0);
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testInOrder();
    testFull();
    testRunahead();
    testNormalReturn();
    testFlushRunahead();
    idle(2);
    finishRun();
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    finishRun();
  end

endmodule